// File: doc/BRIEF.md
# Soft Reset Register Controller

This block sits behind a slave I/O port and turns a read of one dedicated register offset into an internal soft reset. It decodes each access, forwards ordinary accesses to the register banks with a one-cycle strobe, and recognises a correctly sized read of the reset offset. That read starts a fixed-length sequence. During the sequence the control/status bank is held in reset and the access is stalled. The configuration bank is untouched. Ready is returned only when the sequence has finished. A write to the reset offset, or a read of the wrong width, completes normally and does nothing else.

The block also owns the bus-master request line. In normal operation the request follows the data engine. If the request is already up when a soft reset starts, it is held until a grant is sampled and then released without passing the grant to the engine. A hardware reset, by contrast, drops the request within a few cycles without waiting for a grant. It also clears the configuration bank and aborts any soft reset in progress.

The host keeps `io_sel_i` high until it samples `io_rdy_o` high, and removes it in that same ready cycle. The controller state machine has three states:
- `ST_IDLE` accepts an access. It moves to `ST_SRST` for a valid reset read and to `ST_ACK` for any other access.
- `ST_SRST` counts the sequence and moves to `ST_ACK` when the count expires.
- `ST_ACK` gives one cycle of ready and returns to `ST_IDLE`.

A hardware reset forces every state to `ST_IDLE`.

Top module: `sreset_ctrl`

## Requirements
- R1: A read (`io_wr_i`=0) of the reset offset starts a soft reset when it has the right width. In word mode (`io_dword_i`=0) the offset is 0x0C and the byte enables must be 4'b0011. In dword mode (`io_dword_i`=1) the offset is 0x18 and the byte enables must be 4'b1111. `csr_rst_o` is then high for exactly SEQ_LEN (64) consecutive cycles.
- R2: The ready for that read is a single-cycle pulse. It arrives on the SEQ_LEN+1-th rising edge counted from the edge that accepts the read, and it is never high while the sequence runs. The read data returned with it is zero.
- R3: Two kinds of access to the reset offset start no soft reset and raise no bank strobe: a write, and a read whose byte enables do not match the mode. Both complete with ready one edge after acceptance.
- R4: An access to any other offset raises `bank_sel_o` in its accepting cycle only. Its ready comes one edge later, carrying `bank_rdata_i` as the read data.
- R5: A soft reset never asserts `cfg_rst_o`.
- R6: No bank strobe is issued while the sequence runs. The access after the reset read is accepted normally.
- R7: If `bus_req_o` is high when a soft reset starts, it stays high until `bus_gnt_i` is sampled high on a rising edge, even past the end of the sequence and even if the engine has withdrawn. It is low after that edge. `eng_gnt_o` stays low throughout.
- R8: If `bus_req_o` is low when a soft reset starts, it stays low for the whole sequence even if the engine requests. One edge after the sequence it follows `eng_req_i` again.
- R9: A hardware reset (`hw_rst_i` high) brings `bus_req_o` low within 6 rising edges without any grant. While it lasts it holds `cfg_rst_o` and `csr_rst_o` high. After release every output is inactive.
- R10: A hardware reset during a soft reset aborts it, and the aborted read gets no ready. After release a new access completes normally.
- R11: Outside a soft reset, `bus_req_o` equals `eng_req_i` delayed by one edge. `eng_gnt_o` passes `bus_gnt_i` while the request is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_i | input | 1 | Hardware reset, active high, synchronised inside |
| io_sel_i | input | 1 | Access request, held until ready |
| io_wr_i | input | 1 | 1 = write, 0 = read |
| io_dword_i | input | 1 | 1 = dword I/O mode, 0 = word I/O mode |
| io_addr_i | input | ADDR_W | Register offset |
| io_be_i | input | DATA_W/8 | Byte enables |
| io_rdata_o | output | DATA_W | Read data, valid with ready |
| io_rdy_o | output | 1 | One-cycle access completion |
| bank_sel_o | output | 1 | Strobe to the register banks for ordinary accesses |
| bank_rdata_i | input | DATA_W | Read data from the register banks |
| csr_rst_o | output | 1 | Reset to the control/status bank |
| cfg_rst_o | output | 1 | Reset to the configuration bank |
| eng_req_i | input | 1 | Bus request from the data engine |
| eng_gnt_o | output | 1 | Grant passed to the data engine |
| bus_req_o | output | 1 | Bus-master request |
| bus_gnt_i | input | 1 | Bus-master grant |

## Verification
The bench builds the block with its default parameters: SEQ_LEN of 64 and RST_STAGES of 2. The full 64-cycle stall can therefore be measured exactly. The grant can be withheld past the end of the sequence, which exercises the request hold outside the sequence window. A hardware reset can be placed well inside a running sequence. Two synchroniser stages put the request drop at three edges, so the six-edge bound is checked with margin rather than at its limit.

// File: rtl/sreset_pkg.sv
package sreset_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SRST = 2'd1,
        ST_ACK  = 2'd2
    } srst_state_e;

    typedef enum logic [1:0] {
        ACC_BANK    = 2'd0,
        ACC_RST_GO  = 2'd1,
        ACC_RST_NOP = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/sreset_decode.sv
module sreset_decode
    import sreset_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int BE_W      = 4,
    parameter int WORD_OFS  = 'h0C,
    parameter int DWORD_OFS = 'h18
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              wr_i,
    input  logic              dword_i,
    output acc_kind_e         kind_o
);
    localparam logic [BE_W-1:0] FULL_MASK = {BE_W{1'b1}};
    localparam logic [BE_W-1:0] HALF_MASK = {{(BE_W-BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};

    logic hit;
    logic width_ok;

    always_comb begin
        if (dword_i) begin
            hit      = (addr_i == ADDR_W'(DWORD_OFS));
            width_ok = (be_i == FULL_MASK);
        end else begin
            hit      = (addr_i == ADDR_W'(WORD_OFS));
            width_ok = (be_i == HALF_MASK);
        end
        if (!hit) begin
            kind_o = ACC_BANK;
        end else if (!wr_i && width_ok) begin
            kind_o = ACC_RST_GO;
        end else begin
            kind_o = ACC_RST_NOP;
        end
    end
endmodule

// File: rtl/sreset_sync.sv
module sreset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_async_i,
    output logic rst_o
);
    generate
        if (STAGES == 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                q <= rst_async_i;
            end
            assign rst_o = q;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                sh <= {sh[STAGES-2:0], rst_async_i};
            end
            assign rst_o = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sreset_seq_cnt.sv
module sreset_seq_cnt #(
    parameter int SEQ_LEN = 64
) (
    input  logic clk,
    input  logic rst_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sreset_req_arb.sv
module sreset_req_arb (
    input  logic clk,
    input  logic rst_i,
    input  logic start_i,
    input  logic busy_i,
    input  logic eng_req_i,
    input  logic bus_gnt_i,
    output logic bus_req_o,
    output logic eng_gnt_o
);
    logic req_q;
    logic drain_q;

    always_ff @(posedge clk) begin
        if (rst_i) begin
            req_q   <= 1'b0;
            drain_q <= 1'b0;
        end else if (start_i) begin
            drain_q <= req_q;
        end else if (drain_q) begin
            if (bus_gnt_i) begin
                req_q   <= 1'b0;
                drain_q <= 1'b0;
            end
        end else if (busy_i) begin
            req_q <= 1'b0;
        end else begin
            req_q <= eng_req_i;
        end
    end

    assign bus_req_o = req_q;
    assign eng_gnt_o = bus_gnt_i && req_q && !drain_q && !busy_i;
endmodule

// File: rtl/sreset_ctrl.sv
module sreset_ctrl
    import sreset_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int WORD_OFS   = 'h0C,
    parameter int DWORD_OFS  = 'h18,
    parameter int SEQ_LEN    = 64,
    parameter int RST_STAGES = 2
) (
    input  logic                clk,
    input  logic                hw_rst_i,
    input  logic                io_sel_i,
    input  logic                io_wr_i,
    input  logic                io_dword_i,
    input  logic [ADDR_W-1:0]   io_addr_i,
    input  logic [DATA_W/8-1:0] io_be_i,
    output logic [DATA_W-1:0]   io_rdata_o,
    output logic                io_rdy_o,
    output logic                bank_sel_o,
    input  logic [DATA_W-1:0]   bank_rdata_i,
    output logic                csr_rst_o,
    output logic                cfg_rst_o,
    input  logic                eng_req_i,
    output logic                eng_gnt_o,
    output logic                bus_req_o,
    input  logic                bus_gnt_i
);
    localparam int BE_W = DATA_W / 8;

    srst_state_e state_q, state_d;
    acc_kind_e   kind, kind_q;
    logic        rst_q;
    logic        seq_done;
    logic        accept;
    logic        start;
    logic        in_srst;

    sreset_sync #(.STAGES(RST_STAGES)) u_sync (
        .clk         (clk),
        .rst_async_i (hw_rst_i),
        .rst_o       (rst_q)
    );

    sreset_decode #(
        .ADDR_W    (ADDR_W),
        .BE_W      (BE_W),
        .WORD_OFS  (WORD_OFS),
        .DWORD_OFS (DWORD_OFS)
    ) u_dec (
        .addr_i  (io_addr_i),
        .be_i    (io_be_i),
        .wr_i    (io_wr_i),
        .dword_i (io_dword_i),
        .kind_o  (kind)
    );

    sreset_seq_cnt #(.SEQ_LEN(SEQ_LEN)) u_cnt (
        .clk    (clk),
        .rst_i  (rst_q),
        .run_i  (in_srst),
        .done_o (seq_done)
    );

    sreset_req_arb u_arb (
        .clk       (clk),
        .rst_i     (rst_q),
        .start_i   (start),
        .busy_i    (in_srst),
        .eng_req_i (eng_req_i),
        .bus_gnt_i (bus_gnt_i),
        .bus_req_o (bus_req_o),
        .eng_gnt_o (eng_gnt_o)
    );

    assign in_srst = (state_q == ST_SRST);
    assign accept  = (state_q == ST_IDLE) && io_sel_i && !rst_q;
    assign start   = accept && (kind == ACC_RST_GO);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (kind == ACC_RST_GO) ? ST_SRST : ST_ACK;
                end
            end
            ST_SRST: begin
                if (seq_done) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and access-kind capture
    always_ff @(posedge clk) begin
        if (rst_q) begin
            state_q <= ST_IDLE;
            kind_q  <= ACC_BANK;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q <= kind;
            end
        end
    end

    // Outputs
    always_comb begin
        io_rdy_o   = 1'b0;
        io_rdata_o = '0;
        bank_sel_o = 1'b0;
        csr_rst_o  = rst_q;
        cfg_rst_o  = rst_q;
        unique case (state_q)
            ST_IDLE: begin
                bank_sel_o = accept && (kind == ACC_BANK);
            end
            ST_SRST: begin
                csr_rst_o = 1'b1;
            end
            ST_ACK: begin
                io_rdy_o   = !rst_q;
                io_rdata_o = (kind_q == ACC_BANK) ? bank_rdata_i : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sreset_ctrl_chk.sv
module sreset_ctrl_chk (
    input logic clk,
    input logic hw_rst_i,
    input logic cfg_rst_o,
    input logic csr_rst_o,
    input logic io_rdy_o,
    input logic bank_sel_o,
    input logic bus_req_o,
    input logic bus_gnt_i,
    input logic eng_gnt_o
);
    logic [2:0] hw_cnt = 3'd0;

    always_ff @(posedge clk) begin
        if (!hw_rst_i) begin
            hw_cnt <= 3'd0;
        end else if (hw_cnt != 3'd7) begin
            hw_cnt <= hw_cnt + 3'd1;
        end
    end

    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (hw_rst_i || cfg_rst_o)
        io_rdy_o |=> !io_rdy_o); // R2

    AST_STALL_NO_RDY: assert property (@(posedge clk) disable iff (hw_rst_i || cfg_rst_o)
        csr_rst_o |-> !io_rdy_o); // R2

    AST_NO_BANK_IN_SRST: assert property (@(posedge clk) disable iff (hw_rst_i || cfg_rst_o)
        csr_rst_o |-> !bank_sel_o); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (hw_rst_i || cfg_rst_o)
        (csr_rst_o && bus_req_o && !bus_gnt_i) |=> bus_req_o); // R7

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (hw_rst_i || cfg_rst_o)
        (csr_rst_o && bus_req_o && bus_gnt_i) |=> !bus_req_o); // R7

    AST_NO_XFER: assert property (@(posedge clk) disable iff (hw_rst_i || cfg_rst_o)
        csr_rst_o |-> !eng_gnt_o); // R7

    AST_REQ_STAYS_LOW: assert property (@(posedge clk) disable iff (hw_rst_i || cfg_rst_o)
        (csr_rst_o && !bus_req_o) |=> !bus_req_o); // R8

    AST_HW_REQ_DROP: assert property (@(posedge clk)
        (hw_rst_i && hw_cnt >= 3'd6) |-> !bus_req_o); // R9
endmodule

bind sreset_ctrl sreset_ctrl_chk u_chk (
    .clk        (clk),
    .hw_rst_i   (hw_rst_i),
    .cfg_rst_o  (cfg_rst_o),
    .csr_rst_o  (csr_rst_o),
    .io_rdy_o   (io_rdy_o),
    .bank_sel_o (bank_sel_o),
    .bus_req_o  (bus_req_o),
    .bus_gnt_i  (bus_gnt_i),
    .eng_gnt_o  (eng_gnt_o)
);

// File: tb/sim_sreset_ctrl.sv
module sim_sreset_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ        = 64;
    localparam logic [4:0] WOFS = 5'h0C;
    localparam logic [4:0] DOFS = 5'h18;
    localparam logic [4:0] BOFS = 5'h04;
    localparam logic [31:0] BANK_DATA = 32'hA5C3_1E70;

    logic        clk = 1'b0;
    logic        hw_rst_i = 1'b1;
    logic        io_sel_i = 1'b0, io_wr_i = 1'b0, io_dword_i = 1'b0;
    logic [4:0]  io_addr_i = '0;
    logic [3:0]  io_be_i = '0;
    logic [31:0] io_rdata_o, bank_rdata_i = BANK_DATA;
    logic        io_rdy_o, bank_sel_o, csr_rst_o, cfg_rst_o;
    logic        eng_req_i = 1'b0, eng_gnt_o, bus_req_o, bus_gnt_i = 1'b0;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    int lat, csr_n, cfg_n, bank_n, reqlo_n, reqhi_n;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreset_ctrl u0 (
        .clk(clk), .hw_rst_i(hw_rst_i), .io_sel_i(io_sel_i), .io_wr_i(io_wr_i),
        .io_dword_i(io_dword_i), .io_addr_i(io_addr_i), .io_be_i(io_be_i),
        .io_rdata_o(io_rdata_o), .io_rdy_o(io_rdy_o), .bank_sel_o(bank_sel_o),
        .bank_rdata_i(bank_rdata_i), .csr_rst_o(csr_rst_o), .cfg_rst_o(cfg_rst_o),
        .eng_req_i(eng_req_i), .eng_gnt_o(eng_gnt_o), .bus_req_o(bus_req_o),
        .bus_gnt_i(bus_gnt_i)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // One access; host drops sel in the ready cycle.
    task automatic access(input logic [4:0] a, input logic [3:0] be,
                          input bit wr, input bit dw);
        @(negedge clk);
        io_addr_i = a; io_be_i = be; io_wr_i = wr; io_dword_i = dw; io_sel_i = 1'b1;
        #1;
        lat = 0; csr_n = 0; cfg_n = 0; reqlo_n = 0; reqhi_n = 0; rd = 'x;
        bank_n = bank_sel_o ? 1 : 0;
        while (lat < 200) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (csr_rst_o) begin
                csr_n++;
                if (bus_req_o) reqhi_n++; else reqlo_n++;
            end
            if (cfg_rst_o)  cfg_n++;
            if (bank_sel_o) bank_n++;
            if (io_rdy_o) begin
                rd = io_rdata_o;
                break;
            end
        end
        io_sel_i = 1'b0;
    endtask

    task automatic t_reset_state;
        check(csr_rst_o == 1'b0, "R9", "csr_rst after release", csr_rst_o, 0);
        check(cfg_rst_o == 1'b0, "R9", "cfg_rst after release", cfg_rst_o, 0);
        check(bus_req_o == 1'b0, "R9", "bus_req after release", bus_req_o, 0);
        check(io_rdy_o == 1'b0,  "R9", "io_rdy after release", io_rdy_o, 0);
    endtask

    task automatic t_bank_access;
        access(BOFS, 4'b0011, 1'b0, 1'b0);
        check(lat == 1, "R4", "word bank latency", lat, 1);
        check(bank_n == 1, "R4", "bank strobe count", bank_n, 1);
        check(rd == BANK_DATA, "R4", "bank read data", rd, BANK_DATA);
        access(BOFS, 4'b1111, 1'b1, 1'b1);
        check(lat == 1 && bank_n == 1, "R4", "dword bank write latency", lat, 1);
    endtask

    task automatic t_soft(input bit dw);
        access(dw ? DOFS : WOFS, dw ? 4'b1111 : 4'b0011, 1'b0, dw);
        check(csr_n == SEQ, "R1", "csr_rst cycles", csr_n, SEQ);
        check(lat == SEQ + 1, "R2", "reset read latency", lat, SEQ + 1);
        check(rd == 32'h0, "R2", "reset read data", rd, 0);
        check(cfg_n == 0, "R5", "cfg_rst during soft reset", cfg_n, 0);
        check(bank_n == 0, "R6", "bank strobe during reset read", bank_n, 0);
        access(BOFS, 4'b1111, 1'b0, dw);
        check(lat == 1 && rd == BANK_DATA, "R6", "access after reset read", lat, 1);
    endtask

    task automatic t_ignored;
        access(DOFS, 4'b1111, 1'b1, 1'b1);
        check(lat == 1 && csr_n == 0 && bank_n == 0, "R3", "write to reset offset", csr_n, 0);
        access(WOFS, 4'b0001, 1'b0, 1'b0);
        check(lat == 1 && csr_n == 0 && bank_n == 0, "R3", "narrow word reset read", csr_n, 0);
        access(DOFS, 4'b0011, 1'b0, 1'b1);
        check(lat == 1 && csr_n == 0 && bank_n == 0, "R3", "narrow dword reset read", csr_n, 0);
    endtask

    task automatic t_req_drain;
        eng_req_i = 1'b1;
        step(1);
        check(bus_req_o == 1'b1, "R11", "req follows engine", bus_req_o, 1);
        bus_gnt_i = 1'b1; #1;
        check(eng_gnt_o == 1'b1, "R11", "grant passed to engine", eng_gnt_o, 1);
        bus_gnt_i = 1'b0;
        access(DOFS, 4'b1111, 1'b0, 1'b1);
        check(reqlo_n == 0, "R7", "req low cycles during soft reset", reqlo_n, 0);
        eng_req_i = 1'b0;
        step(3);
        check(bus_req_o == 1'b1, "R7", "req held past sequence without grant", bus_req_o, 1);
        bus_gnt_i = 1'b1; #1;
        check(eng_gnt_o == 1'b0, "R7", "no grant to engine in drain", eng_gnt_o, 0);
        step(1);
        check(bus_req_o == 1'b0, "R7", "req low after grant edge", bus_req_o, 1'b0);
        bus_gnt_i = 1'b0;
        eng_req_i = 1'b1;
        step(1);
        check(bus_req_o == 1'b1, "R11", "req resumes after drain", bus_req_o, 1);
        eng_req_i = 1'b0;
        step(2);
    endtask

    task automatic t_req_idle;
        check(bus_req_o == 1'b0, "R8", "req low before read", bus_req_o, 0);
        fork
            access(WOFS, 4'b0011, 1'b0, 1'b0);
            begin
                step(5);
                eng_req_i = 1'b1;
            end
        join
        check(reqhi_n == 0 && csr_n == SEQ, "R8", "req high cycles during soft reset", reqhi_n, 0);
        step(1);
        check(bus_req_o == 1'b1, "R8", "req follows engine after sequence", bus_req_o, 1);
        eng_req_i = 1'b0;
        step(2);
    endtask

    task automatic t_hw_req;
        int n;
        eng_req_i = 1'b1;
        step(2);
        check(bus_req_o == 1'b1, "R9", "req up before hw reset", bus_req_o, 1);
        hw_rst_i = 1'b1;
        n = 0;
        while (n < 10) begin
            step(1);
            n++;
            if (!bus_req_o) break;
        end
        check(n <= 6 && !bus_req_o, "R9", "edges to req drop", n, 6);
        check(cfg_rst_o && csr_rst_o, "R9", "both bank resets in hw reset", {cfg_rst_o, csr_rst_o}, 3);
        eng_req_i = 1'b0;
        hw_rst_i = 1'b0;
        step(4);
        t_reset_state();
    endtask

    task automatic t_hw_abort;
        int rdy_n;
        rdy_n = 0;
        @(negedge clk);
        io_addr_i = DOFS; io_be_i = 4'b1111; io_wr_i = 1'b0; io_dword_i = 1'b1; io_sel_i = 1'b1;
        step(20);
        check(csr_rst_o && !cfg_rst_o, "R10", "sequence running before hw reset", csr_rst_o, 1);
        hw_rst_i = 1'b1;
        io_sel_i = 1'b0;
        repeat (6) begin
            step(1);
            if (io_rdy_o) rdy_n++;
        end
        check(cfg_rst_o && csr_rst_o, "R10", "hw reset overrides soft reset", {cfg_rst_o, csr_rst_o}, 3);
        hw_rst_i = 1'b0;
        repeat (70) begin
            step(1);
            if (io_rdy_o) rdy_n++;
        end
        check(rdy_n == 0, "R10", "ready for aborted read", rdy_n, 0);
        check(!csr_rst_o && !cfg_rst_o, "R10", "idle after release", csr_rst_o, 0);
        access(BOFS, 4'b1111, 1'b0, 1'b1);
        check(lat == 1 && rd == BANK_DATA, "R10", "access after abort", lat, 1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        hw_rst_i = 1'b0;
        step(4);
        t_reset_state();
        t_bank_access();
        t_soft(1'b0);
        t_soft(1'b1);
        t_ignored();
        t_req_drain();
        t_req_idle();
        t_hw_req();
        t_hw_abort();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule